// File: doc/BRIEF.md
# Sixteen-bit reload/capture timer

This block is a 16-bit timer/counter with a companion 16-bit reload/capture register. Each step comes either from a clock-enable tick or from a falling edge on an external count pin. Software programs the block through a byte-wide write port and reads it back through a byte-wide read port.

In reload mode, a rollover loads the counter from the companion register. Reload mode can also count in both directions, with the direction taken from the level of an external trigger pin. In capture mode, a falling edge on the trigger pin copies the running count into the companion register. Either select bit of the two baud-clock select bits puts the block into baud mode. In baud mode the block reloads on every rollover and emits a one-cycle baud tick, with no overflow flag and no trigger action. A downstream divider turns the tick rate, tick/(65536 − reload), into a bit rate.

The overflow flag and the trigger flag are sticky. Each one stays set until software writes a 0 to it.

Top module: `rc_timer16`

## Requirements
- R1: After reset every readable register reads 0x00, and `ovf_flag`, `ext_flag` and `baud_tick` are low. The register map is as follows. Address 0 is control, with bit0 run, bit1 trigger enable, bit2 capture select, bit3 count-pin source, bit4 receive-baud select, bit5 transmit-baud select, bit6 trigger flag and bit7 overflow flag. Address 1 is mode, with bit0 up/down enable. Addresses 2 and 3 are the counter low and high bytes, and addresses 4 and 5 are the reload/capture low and high bytes.
- R2: With run=1, count-pin source=0 and up/down enable=0, the counter rises by one on every clock in which `tick` is high.
- R3: In reload mode (capture select=0), an upward step from 0xFFFF loads the counter from the reload/capture register.
- R4: A rollover outside baud mode sets the overflow flag (control bit7).
- R5: Writing 0 to control bit6 or bit7 clears that flag. Writing 1 to either bit leaves it unchanged.
- R6: With run=0, the counter holds its value while `tick` pulses.
- R7: With up/down enable=1 in reload mode, the counter counts up while `trig_pin` is high and down while it is low. A down step taken when the counter equals the reload value loads 0xFFFF and sets the overflow flag.
- R8: In capture mode with trigger enable=1, a falling edge on `trig_pin` copies the counter into the reload/capture register and sets control bit6. The counter is not changed.
- R9: In capture mode, an upward step from 0xFFFF wraps the counter to 0x0000 and sets the overflow flag.
- R10: In reload mode with trigger enable=1, a falling edge on `trig_pin` loads the counter from the reload/capture register and sets control bit6.
- R11: If control bit4 or bit5 is 1, a rollover reloads from the reload/capture register whatever the capture select bit holds. It also drives `baud_tick` high for one cycle and does not set the overflow flag. Outside baud mode `baud_tick` stays low.
- R12: In baud mode, a falling edge on `trig_pin` changes neither the counter, nor the reload/capture register, nor control bit6.
- R13: With count-pin source=1, the counter steps once per falling edge of `cnt_pin` and ignores `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable for the internal source |
| cnt_pin | input | 1 | Asynchronous external count input |
| trig_pin | input | 1 | Asynchronous trigger and direction input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky trigger-edge flag |
| baud_tick | output | 1 | One-cycle pulse per rollover in baud mode |

## Verification
The assertions assume the following about the inputs. A flag rises only in a cycle after the matching enable and mode were already set. Only a software write to control can lower a flag. With run and trigger enable both off and no write, the counter cannot move.

The stimulus respects the synchronizer latency. Both pins are held at each level for at least four clocks, so that every edge is seen exactly once. `tick` is kept low while registers are written or read back, so each readback compares against a count that is not moving.

// File: rtl/rct_pkg.sv
// Shared register addresses, control bit positions and configuration type
// for the reload/capture timer. Assumes an 8-bit register port.
package rct_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE   = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd5;

    localparam int B_RUN  = 0;
    localparam int B_EXEN = 1;
    localparam int B_CAP  = 2;
    localparam int B_SRC  = 3;
    localparam int B_RXB  = 4;
    localparam int B_TXB  = 5;
    localparam int B_EXTF = 6;
    localparam int B_OVFF = 7;

    typedef struct packed {
        logic run;
        logic ext_en;
        logic cap_sel;
        logic src_pin;
        logic rx_baud;
        logic tx_baud;
        logic updown;
    } cfg_t;
endpackage

// File: rtl/rct_edge_sync.sv
// Synchronizes an asynchronous pin through STAGES flops and reports
// a one-cycle pulse on each falling edge of the synchronized level.
// Assumes the pin holds each level for longer than STAGES+1 clocks.
module rct_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            // Single-flop capture of the pin
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= pin;
            end
        end else begin : g_many
            // Shift the pin through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], pin};
            end
        end
    endgenerate

    // Remember the last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign fall  = prev & ~chain[STAGES-1];
endmodule

// File: rtl/rct_ctrl.sv
// Control and mode register with the two sticky flags. A hardware set
// wins over a software clear in the same cycle; writing 1 to a flag
// bit leaves it as it was.
module rct_ctrl
    import rct_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              set_ovf,
    input  logic              set_ext,
    output cfg_t              cfg,
    output logic              ovf_flag,
    output logic              ext_flag
);
    logic wr_ctrl;
    logic wr_mode;

    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign wr_mode = wr_en && (wr_addr == A_MODE);

    // Configuration bits follow software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg.run     <= wr_data[B_RUN];
                cfg.ext_en  <= wr_data[B_EXEN];
                cfg.cap_sel <= wr_data[B_CAP];
                cfg.src_pin <= wr_data[B_SRC];
                cfg.rx_baud <= wr_data[B_RXB];
                cfg.tx_baud <= wr_data[B_TXB];
            end
            if (wr_mode) cfg.updown <= wr_data[0];
        end
    end

    // Sticky flags: set by hardware, cleared only by writing 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            ext_flag <= 1'b0;
        end else begin
            ovf_flag <= set_ovf | (ovf_flag & ~(wr_ctrl & ~wr_data[B_OVFF]));
            ext_flag <= set_ext | (ext_flag & ~(wr_ctrl & ~wr_data[B_EXTF]));
        end
    end
endmodule

// File: rtl/rct_count.sv
// Counter and reload/capture register. Computes the step, direction,
// rollover and trigger action each cycle; software byte writes take
// priority over hardware updates of the same register.
module rct_count
    import rct_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    input  logic              tick,
    input  logic              pin_fall,
    input  logic              trig_level,
    input  logic              trig_fall,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [2*DW-1:0]   cnt,
    output logic [2*DW-1:0]   cap,
    output logic              set_ovf,
    output logic              set_ext,
    output logic              baud_tick
);
    localparam int CW = 2 * DW;
    localparam logic [CW-1:0] ALL1 = '1;

    logic          baud;
    logic          reload_mode;
    logic          down;
    logic          step;
    logic          ext_hit;
    logic          roll;
    logic [CW-1:0] cnt_nx;
    logic [CW-1:0] cap_nx;

    assign baud        = cfg.rx_baud | cfg.tx_baud;
    assign reload_mode = baud | ~cfg.cap_sel;
    assign down        = cfg.updown & reload_mode & ~baud & ~trig_level;
    assign step        = cfg.run & (cfg.src_pin ? pin_fall : tick);
    assign ext_hit     = cfg.ext_en & trig_fall & ~baud;

    // Next-state of counter and reload/capture register
    always_comb begin
        cnt_nx = cnt;
        cap_nx = cap;
        roll   = 1'b0;
        if (step) begin
            if (down) begin
                if (cnt == cap) begin
                    cnt_nx = ALL1;
                    roll   = 1'b1;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end else if (cnt == ALL1) begin
                roll   = 1'b1;
                cnt_nx = reload_mode ? cap : '0;
            end else begin
                cnt_nx = cnt + 1'b1;
            end
        end
        if (ext_hit) begin
            if (reload_mode) cnt_nx = cap;
            else             cap_nx = cnt;
        end
        if (wr_en) begin
            case (wr_addr)
                A_CNT_LO: cnt_nx[DW-1:0]  = wr_data;
                A_CNT_HI: cnt_nx[CW-1:DW] = wr_data;
                A_CAP_LO: cap_nx[DW-1:0]  = wr_data;
                A_CAP_HI: cap_nx[CW-1:DW] = wr_data;
                default: ;
            endcase
        end
    end

    assign set_ovf = roll & ~baud;
    assign set_ext = ext_hit;

    // Register counter, reload/capture value and baud pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            cap       <= '0;
            baud_tick <= 1'b0;
        end else begin
            cnt       <= cnt_nx;
            cap       <= cap_nx;
            baud_tick <= roll & baud;
        end
    end
endmodule

// File: rtl/rc_timer16.sv
// Top of the reload/capture timer: two pin synchronizers, the control
// register, the counter datapath and a combinational read multiplexer.
// Assumes DW=8 for the control byte; wider DW zero-extends it.
module rc_timer16
    import rct_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              ovf_flag,
    output logic              ext_flag,
    output logic              baud_tick
);
    localparam int CW = 2 * DW;

    cfg_t          cfg_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cap_q;
    logic          pin_lvl;
    logic          pin_fall;
    logic          trig_lvl;
    logic          trig_fall;
    logic          set_ovf;
    logic          set_ext;
    logic [7:0]    ctrl_byte;

    rct_edge_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .level(pin_lvl), .fall(pin_fall)
    );

    rct_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk(clk), .rst_n(rst_n), .pin(trig_pin), .level(trig_lvl), .fall(trig_fall)
    );

    rct_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .set_ovf(set_ovf), .set_ext(set_ext), .cfg(cfg_q),
        .ovf_flag(ovf_flag), .ext_flag(ext_flag)
    );

    rct_count #(.DW(DW)) u_count (
        .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .tick(tick), .pin_fall(pin_fall),
        .trig_level(trig_lvl), .trig_fall(trig_fall), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt(cnt_q), .cap(cap_q), .set_ovf(set_ovf),
        .set_ext(set_ext), .baud_tick(baud_tick)
    );

    // Assemble the control byte from configuration and flags
    always_comb begin
        ctrl_byte         = '0;
        ctrl_byte[B_RUN]  = cfg_q.run;
        ctrl_byte[B_EXEN] = cfg_q.ext_en;
        ctrl_byte[B_CAP]  = cfg_q.cap_sel;
        ctrl_byte[B_SRC]  = cfg_q.src_pin;
        ctrl_byte[B_RXB]  = cfg_q.rx_baud;
        ctrl_byte[B_TXB]  = cfg_q.tx_baud;
        ctrl_byte[B_EXTF] = ext_flag;
        ctrl_byte[B_OVFF] = ovf_flag;
    end

    // Select the register addressed by the read port
    always_comb begin
        case (rd_addr)
            A_CTRL:   rd_data = DW'(ctrl_byte);
            A_MODE:   rd_data = DW'(cfg_q.updown);
            A_CNT_LO: rd_data = cnt_q[DW-1:0];
            A_CNT_HI: rd_data = cnt_q[CW-1:DW];
            A_CAP_LO: rd_data = cap_q[DW-1:0];
            A_CAP_HI: rd_data = cap_q[CW-1:DW];
            default:  rd_data = '0;
        endcase
    end

    // The synchronized count-pin level is only used through its edge
    logic unused_lvl;
    assign unused_lvl = pin_lvl;
endmodule

// File: rtl/rct_chk.sv
// Property checker for the reload/capture timer, bound to the top.
// Assumes flags change only through hardware events or control writes.
module rct_chk
    import rct_pkg::*;
#(
    parameter int CW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              ext_en,
    input logic              baud,
    input logic              ovf_flag,
    input logic              ext_flag,
    input logic              baud_tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CW-1:0]     cnt
);
    // R4
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(run) && !$past(baud)));

    // R11
    baud_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> ($past(run) && $past(baud)));

    // R12
    ext_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_flag) |-> ($past(ext_en) && !$past(baud)));

    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(wr_en && wr_addr == A_CTRL)) |=> ovf_flag);

    // R5
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_flag && !(wr_en && wr_addr == A_CTRL)) |=> ext_flag);

    // R6
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ext_en && !wr_en) |=> $stable(cnt));
endmodule

bind rc_timer16 rct_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(cfg_q.run), .ext_en(cfg_q.ext_en),
    .baud(cfg_q.rx_baud | cfg_q.tx_baud), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
    .baud_tick(baud_tick), .wr_en(wr_en), .wr_addr(wr_addr), .cnt(cnt_q)
);

// File: tb/sim_rc_timer16.sv
// Scoreboard bench: read tasks queue expected bytes, a negedge monitor
// pops and compares them against rd_data and counts baud pulses.
module sim_rc_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cnt_pin = 1'b1;
    logic       trig_pin = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ovf_flag;
    logic       ext_flag;
    logic       baud_tick;

    int nchk = 0;
    int nfail = 0;
    int bcnt = 0;
    bit done = 0;

    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #5 clk = ~clk;

    rc_timer16 u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .ovf_flag(ovf_flag), .ext_flag(ext_flag), .baud_tick(baud_tick)
    );

    task automatic check(input int act, input int exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare queued expectations and count baud pulses
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            logic [7:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check(int'(rd_data), int'(e), t);
        end
        if (rst_n && baud_tick) bcnt++;
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        rd_addr = a;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk); #1;
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #1;
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        for (int a = 0; a < 6; a++) rd_chk(3'(a), 8'h00, "R1 reset reg");
        check(int'({ovf_flag, ext_flag, baud_tick}), 0, "R1 reset outputs");

        // R2 up count on tick
        wr(3'd2, 8'hFE); wr(3'd3, 8'h00); wr(3'd0, 8'h01);
        ticks(5);
        rd_chk(3'd2, 8'h03, "R2 cnt lo");
        rd_chk(3'd3, 8'h01, "R2 cnt hi");

        // R3 R4 reload on rollover and overflow flag
        wr(3'd4, 8'h34); wr(3'd5, 8'h12); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
        ticks(3);
        rd_chk(3'd2, 8'h35, "R3 cnt lo");
        rd_chk(3'd3, 8'h12, "R3 cnt hi");
        rd_chk(3'd0, 8'h81, "R4 ovf flag");
        check(bcnt, 0, "R11 no baud tick outside baud mode");

        // R5 flag write semantics
        wr(3'd0, 8'hC1);
        rd_chk(3'd0, 8'h81, "R5 write 1 keeps flag");
        wr(3'd0, 8'h01);
        rd_chk(3'd0, 8'h01, "R5 write 0 clears flag");

        // R6 run off holds count
        wr(3'd0, 8'h00);
        ticks(4);
        rd_chk(3'd2, 8'h35, "R6 cnt lo frozen");
        rd_chk(3'd3, 8'h12, "R6 cnt hi frozen");

        // R7 down count with trigger low, reload 0xFFFF at reload value
        trig_pin = 1'b0;
        wait_cyc(4);
        wr(3'd1, 8'h01); wr(3'd2, 8'h36); wr(3'd3, 8'h12); wr(3'd0, 8'h01);
        rd_chk(3'd1, 8'h01, "R7 mode readback");
        ticks(3);
        rd_chk(3'd2, 8'hFF, "R7 down wrap lo");
        rd_chk(3'd3, 8'hFF, "R7 down wrap hi");
        rd_chk(3'd0, 8'h81, "R7 down ovf flag");
        wr(3'd0, 8'h01);
        trig_pin = 1'b1;
        wait_cyc(4);
        ticks(2);
        rd_chk(3'd2, 8'h35, "R7 up after high lo");
        rd_chk(3'd3, 8'h12, "R7 up after high hi");
        rd_chk(3'd0, 8'h81, "R7 up ovf flag");
        wr(3'd1, 8'h00);

        // R8 capture on trigger falling edge
        wr(3'd0, 8'h07); wr(3'd2, 8'h00); wr(3'd3, 8'h05);
        ticks(16);
        trig_pin = 1'b0;
        wait_cyc(5);
        rd_chk(3'd4, 8'h10, "R8 cap lo");
        rd_chk(3'd5, 8'h05, "R8 cap hi");
        rd_chk(3'd2, 8'h10, "R8 cnt unchanged");
        rd_chk(3'd0, 8'h47, "R8 ext flag");

        // R9 capture mode wraps to zero
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        ticks(1);
        rd_chk(3'd2, 8'h00, "R9 wrap lo");
        rd_chk(3'd3, 8'h00, "R9 wrap hi");
        rd_chk(3'd0, 8'hC7, "R9 ovf flag");

        // R10 reload on trigger edge in reload mode
        wr(3'd0, 8'h03); wr(3'd2, 8'h0A); wr(3'd3, 8'h0A);
        trig_pin = 1'b1;
        wait_cyc(4);
        trig_pin = 1'b0;
        wait_cyc(5);
        rd_chk(3'd2, 8'h10, "R10 reload lo");
        rd_chk(3'd3, 8'h05, "R10 reload hi");
        rd_chk(3'd0, 8'h43, "R10 ext flag");

        // R11 baud mode: reload despite capture select, pulses, no ovf
        wr(3'd4, 8'hFC); wr(3'd5, 8'hFF); wr(3'd2, 8'hFC); wr(3'd3, 8'hFF);
        wr(3'd0, 8'h27);
        ticks(8);
        wait_cyc(2);
        check(bcnt, 2, "R11 baud pulse count");
        rd_chk(3'd2, 8'hFC, "R11 cnt lo");
        rd_chk(3'd3, 8'hFF, "R11 cnt hi");
        rd_chk(3'd0, 8'h27, "R11 no ovf flag");
        wr(3'd0, 8'h17); wr(3'd2, 8'hFF);
        ticks(1);
        wait_cyc(2);
        check(bcnt, 3, "R11 receive-baud pulse");
        rd_chk(3'd2, 8'hFC, "R11 receive-baud reload");
        rd_chk(3'd0, 8'h17, "R11 receive-baud no ovf");

        // R12 baud mode ignores trigger edge
        wr(3'd2, 8'h11); wr(3'd3, 8'h11);
        trig_pin = 1'b1;
        wait_cyc(4);
        trig_pin = 1'b0;
        wait_cyc(5);
        rd_chk(3'd2, 8'h11, "R12 cnt unchanged");
        rd_chk(3'd4, 8'hFC, "R12 cap unchanged");
        rd_chk(3'd0, 8'h17, "R12 no ext flag");

        // R13 count falling edges of the count pin, ignore tick
        wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h09);
        @(posedge clk); #1 tick = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cnt_pin = 1'b0;
            wait_cyc(4);
            cnt_pin = 1'b1;
            wait_cyc(4);
        end
        tick = 1'b0;
        wait_cyc(4);
        rd_chk(3'd2, 8'h03, "R13 pin edges lo");
        rd_chk(3'd3, 8'h00, "R13 pin edges hi");

        wait_cyc(2);
        finish_run();
    end
endmodule